// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets any of several processor cores interrupt another core and hand it a 16-bit message in the same operation. Each core owns a pair of 32-bit registers, a command register and a mailbox register, and drives one interrupt line. A core writes its command register to post a message to a target core. The target's mailbox then holds the sender's index and the payload with a pending flag set, and the target's interrupt line rises. The target reads its mailbox and clears the pending flag with an acknowledge command through its own command register. A single command write can post to another core and acknowledge the writer's own message at once.

Access uses a simple single-cycle register bus. A write is taken at the rising clock edge when the write enable is high. Read data is a combinational function of the address. The number of cores and the address width are parameters.

The design works without a state register. Each bus write is classified into one of five named operation kinds: none, store, post, acknowledge, or post-and-acknowledge. That kind selects the register updates for the edge.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset, every command and mailbox register reads zero and every interrupt line is low.
- R2: The core index is address bits [ADDR_W-1:3]. Address bit 2 selects the command register (0) or the mailbox register (1), and bits [1:0] are ignored. An index of NUM_CORES or more reads as zero and ignores writes.
- R3: A write to a command register stores the whole 32-bit word, whatever command bits it carries. A read returns the stored word.
- R4: A command write with bit 30 (post) set and a destination in bits 29:16 below NUM_CORES loads that destination's mailbox with the following value: bit 31 = 0, bit 30 = 1, bits 29:16 = the writer's index, bits 15:0 = the written bits 15:0. The destination's interrupt line is high from the next clock edge.
- R5: A command write with bit 31 (acknowledge) set clears bit 30 of the writer's own mailbox, keeps all its other bits, and drops the writer's interrupt line.
- R6: Post is applied before acknowledge. A core that posts to itself with both bits set ends with a mailbox of {0, 0, own index, payload} and its line low.
- R7: Writes to a mailbox register change no register and no interrupt line.
- R8: A post whose destination is NUM_CORES or more changes no mailbox and no interrupt line. The command word is still stored.
- R9: Each interrupt line is a level equal to its mailbox bit 30. It stays high through unrelated writes until that core acknowledges.
- R10: A post to a core whose pending flag is already set replaces the source and payload, and the flag stays set.
- R11: Register updates take effect at the clock edge that samples the write. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | NUM_CORES | Interrupt line per core |

## Verification
Posting and acknowledging are the two functions that can meet in one cycle. A single command write carries both bits, and it either targets another core or targets the writer itself. The bench provokes both forms directly, and the random phase produces them again with random pending histories. A behavioural model applies the post first and the acknowledge second. After every write the model is compared with each mailbox, each command register and each interrupt line, so a reversed order shows up as a wrong pending flag or a line left high.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

    localparam int WORD_W     = 32;
    localparam int CORE_FLD_W = 14;
    localparam int PAYLOAD_W  = 16;
    localparam int BIT_ACK    = 31;
    localparam int BIT_POST   = 30;
    localparam int BIT_PEND   = 30;
    localparam int DST_LSB    = 16;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STORE,
        OP_POST,
        OP_ACK,
        OP_POST_ACK
    } op_e;

    function automatic logic [WORD_W-1:0] mbox_word(
        input logic                  pend,
        input logic [CORE_FLD_W-1:0] src,
        input logic [PAYLOAD_W-1:0]  pl
    );
        return {1'b0, pend, src, pl};
    endfunction

endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6,
    localparam int IDX_W    = ADDR_W - 3
) (
    input  logic [ADDR_W-1:2] addr_hi,
    input  logic              we,
    output logic [IDX_W-1:0]  core_idx,
    output logic              sel_mbox,
    output logic              in_range,
    output logic              wr_cmd
);

    always_comb begin
        core_idx = addr_hi[ADDR_W-1:3];
        sel_mbox = addr_hi[2];
        in_range = (int'(core_idx) < NUM_CORES);
        wr_cmd   = we && in_range && !sel_mbox;
    end

endmodule

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_mbox_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                  wr_cmd,
    input  logic [WORD_W-1:0]     wdata,
    output op_e                   op,
    output logic [CORE_FLD_W-1:0] dst,
    output logic                  dst_ok,
    output logic [PAYLOAD_W-1:0]  payload
);

    logic [1:0] bits;

    always_comb begin
        dst     = wdata[DST_LSB +: CORE_FLD_W];
        payload = wdata[PAYLOAD_W-1:0];
        dst_ok  = (int'(dst) < NUM_CORES);
        bits    = {wdata[BIT_POST], wdata[BIT_ACK]};
        op      = OP_NONE;
        if (wr_cmd) begin
            unique case (bits)
                2'b00: op = OP_STORE;
                2'b10: op = OP_POST;
                2'b01: op = OP_ACK;
                2'b11: op = OP_POST_ACK;
                default: op = OP_STORE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
    import ipi_mbox_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_we,
    input  logic [WORD_W-1:0]     cmd_wdata,
    input  logic                  post_hit,
    input  logic [CORE_FLD_W-1:0] post_src,
    input  logic [PAYLOAD_W-1:0]  post_payload,
    input  logic                  ack_hit,
    output logic [WORD_W-1:0]     cmd_q,
    output logic [WORD_W-1:0]     mbox_q,
    output logic                  irq_o
);

    logic [WORD_W-1:0] mbox_d;

    // post first, acknowledge second
    always_comb begin
        mbox_d = mbox_q;
        if (post_hit) begin
            mbox_d = mbox_word(1'b1, post_src, post_payload);
        end
        if (ack_hit) begin
            mbox_d[BIT_PEND] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            mbox_q <= '0;
        end else begin
            if (cmd_we) begin
                cmd_q <= cmd_wdata;
            end
            mbox_q <= mbox_d;
        end
    end

    assign irq_o = mbox_q[BIT_PEND];

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_mbox_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq
);

    localparam int IDX_W = ADDR_W - 3;

    logic                  unused_addr_lo;
    logic [IDX_W-1:0]      core_idx;
    logic                  sel_mbox;
    logic                  in_range;
    logic                  wr_cmd;
    op_e                   op;
    logic [CORE_FLD_W-1:0] dst;
    logic                  dst_ok;
    logic [PAYLOAD_W-1:0]  payload;
    logic                  do_post;
    logic                  do_ack;
    logic [CORE_FLD_W-1:0] src_fld;

    logic [WORD_W-1:0] cmd_arr  [NUM_CORES];
    logic [WORD_W-1:0] mbox_arr [NUM_CORES];

    assign unused_addr_lo = ^bus_addr[1:0];

    ipi_bus_decode #(
        .NUM_CORES(NUM_CORES),
        .ADDR_W   (ADDR_W)
    ) u_bus (
        .addr_hi (bus_addr[ADDR_W-1:2]),
        .we      (bus_we),
        .core_idx(core_idx),
        .sel_mbox(sel_mbox),
        .in_range(in_range),
        .wr_cmd  (wr_cmd)
    );

    ipi_cmd_decode #(
        .NUM_CORES(NUM_CORES)
    ) u_cmd (
        .wr_cmd (wr_cmd),
        .wdata  (bus_wdata),
        .op     (op),
        .dst    (dst),
        .dst_ok (dst_ok),
        .payload(payload)
    );

    always_comb begin
        do_post = 1'b0;
        do_ack  = 1'b0;
        unique case (op)
            OP_NONE:     ;
            OP_STORE:    ;
            OP_POST:     do_post = dst_ok;
            OP_ACK:      do_ack  = 1'b1;
            OP_POST_ACK: begin
                do_post = dst_ok;
                do_ack  = 1'b1;
            end
            default:     ;
        endcase
    end

    assign src_fld = CORE_FLD_W'(core_idx);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        logic sel_me;
        assign sel_me = (int'(core_idx) == g);

        ipi_core_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_we      (wr_cmd && sel_me),
            .cmd_wdata   (bus_wdata),
            .post_hit    (do_post && (int'(dst) == g)),
            .post_src    (src_fld),
            .post_payload(payload),
            .ack_hit     (do_ack && sel_me),
            .cmd_q       (cmd_arr[g]),
            .mbox_q      (mbox_arr[g]),
            .irq_o       (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            if (in_range && int'(core_idx) == k) begin
                bus_rdata = sel_mbox ? mbox_arr[k] : cmd_arr[k];
            end
        end
    end

endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [NUM_CORES-1:0] irq
);

    logic wr_c;
    logic wr_m;
    logic bad_dst;
    int   widx;
    int   wdst;

    always_comb begin
        widx    = int'(bus_addr[ADDR_W-1:3]);
        wdst    = int'(bus_wdata[29:16]);
        wr_c    = bus_we && (widx < NUM_CORES) && !bus_addr[2];
        wr_m    = bus_we && (widx < NUM_CORES) && bus_addr[2];
        bad_dst = wdst >= NUM_CORES;
    end

    always @(posedge clk) begin
        // R1
        rst_quiet_chk: assert (rst_n || irq == '0)
            else $error("irq high during reset");
    end

    // R7
    mbox_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_m |=> $stable(irq));

    // R9
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(irq));

    // R8
    bad_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && bus_wdata[30] && bad_dst && !bus_wdata[31]) |=> $stable(irq));

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        // R4
        post_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_c && bus_wdata[30] && wdst == k && !(bus_wdata[31] && widx == k))
            |=> irq[k]);

        // R5
        ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_c && bus_wdata[31] && widx == k) |=> !irq[k]);

        // R9
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[k] && !(wr_c && bus_wdata[31] && widx == k)) |=> irq[k]);
    end

endmodule

bind ipi_mailbox ipi_mailbox_chk #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .irq      (irq)
);

// File: tb/sim_ipi_mailbox.sv
`timescale 1ns/1ps
module sim_ipi_mailbox;

    localparam int N  = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cmd  [N];
    logic [31:0] m_mbox [N];

    always #2.5 clk = ~clk;

    ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] a_of(input int core, input bit mbox);
        return AW'((core << 3) | (mbox ? 4 : 0));
    endfunction

    // behavioural model: post applied, then acknowledge
    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        int idx = int'(a) >> 3;
        int dst = int'(d[29:16]);
        if (idx < N && !a[2]) begin
            m_cmd[idx] = d;
            if (d[30] && dst < N)
                m_mbox[dst] = 32'h4000_0000 | (32'(idx) << 16) | {16'h0, d[15:0]};
            if (d[31])
                m_mbox[idx] = m_mbox[idx] & ~32'h4000_0000;
        end
    endtask

    task automatic compare_all(input string req);
        logic [N-1:0] exp_irq;
        for (int i = 0; i < N; i++) begin
            exp_irq[i] = m_mbox[i][30];
            bus_addr = a_of(i, 1'b0);
            #0.2;
            chk({req, " R3 cmd read"}, bus_rdata, m_cmd[i]);
            bus_addr = a_of(i, 1'b1);
            #0.2;
            chk({req, " R11 mbox read"}, bus_rdata, m_mbox[i]);
        end
        chk({req, " R9 irq level"}, 32'(irq), 32'(exp_irq));
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
        compare_all(req);
    endtask

    function automatic logic [31:0] cmd(input bit ack, input bit post, input int dst, input logic [15:0] pl);
        return {ack, post, 14'(dst), pl};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m_cmd[i]  = '0;
            m_mbox[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk("R1 irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after reset");

        wr(a_of(0, 0), cmd(0, 1, 2, 16'hBEEF), "R4 post 0->2");
        chk("R4 mbox2", m_mbox[2], 32'h4000_BEEF);
        // R2: low address bits ignored
        bus_addr = a_of(2, 1) | AW'(3);
        #0.2;
        chk("R2 low bits ignored", bus_rdata, 32'h4000_BEEF);

        wr(a_of(1, 0), cmd(0, 1, 2, 16'h1234), "R10 overwrite");
        chk("R10 new source kept", m_mbox[2], 32'h4001_1234);
        wr(a_of(1, 0), 32'h0000_5A5A, "R3 plain store");
        wr(a_of(2, 1), 32'h0000_0000, "R7 mbox write ignored");
        wr(a_of(2, 1), 32'hFFFF_FFFF, "R7 mbox write ones ignored");
        wr(a_of(2, 0), cmd(1, 0, 0, 16'h0), "R5 ack");
        chk("R5 other bits kept", m_mbox[2], 32'h0001_1234);

        wr(a_of(3, 0), cmd(1, 1, 3, 16'h7777), "R6 self post+ack");
        chk("R6 model", m_mbox[3], 32'h0003_7777);

        wr(a_of(0, 0), cmd(0, 1, 5, 16'h1111), "R8 dst 5");
        wr(a_of(0, 0), cmd(0, 1, 16'h3FFF, 16'h2222), "R8 dst max");

        // R2: out-of-range core index
        wr(a_of(6, 0), cmd(0, 1, 1, 16'h3333), "R2 window write");
        bus_addr = a_of(6, 0);
        #0.2;
        chk("R2 window read zero", bus_rdata, 32'h0);

        // both functions in one write, different cores
        wr(a_of(1, 0), cmd(0, 1, 3, 16'hAAAA), "R4 post 1->3");
        wr(a_of(3, 0), cmd(1, 1, 0, 16'hCCCC), "R6 post 3->0 with ack");
        chk("R6 irq3 low", 32'(irq[3]), 32'h0);
        chk("R6 irq0 high", 32'(irq[0]), 32'h1);

        begin
            logic [31:0] lf = 32'hACE1_2357;
            for (int n = 0; n < 300; n++) begin
                logic [31:0] d;
                logic [AW-1:0] a;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                a = AW'(lf[7:2] & 6'h2F) & ~AW'(lf[8] ? 0 : 4);
                d = {lf[31:30], 11'h0, lf[12:10] & 3'h7, lf[27:12]};
                if (lf[9]) d[29:16] = 14'(lf[11:10]);
                wr(a, d, "R4 R5 R6 random");
            end
        end

        rst_n = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_cmd[i]  = '0;
            m_mbox[i] = '0;
        end
        #1;
        compare_all("R1 re-reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule